// File: doc/BRIEF.md
# Digital Type-II Angle Tracking Loop

This block is the digital heart of a single-channel tracking angle converter. Once per excitation period, an upstream demodulator delivers a signed sample proportional to the sine of the difference between the true shaft angle and the angle currently held in the block. A strobe marks each sample. The sample feeds a proportional-plus-integral filter. A first-order smoothing stage follows the filter, and its output sets the rate of a phase-accumulating pulse generator. Every pulse moves a 14-bit up/down angle register by one count, in the direction that reduces the error. No convert command is needed: the register simply follows the shaft.

The loop contains two integrations: the filter integrator and the pulse generator. It is therefore Type II. At a constant shaft speed the integrator settles at a value that reproduces the speed exactly, so the mean following error is zero and only acceleration leaves a residue. The integrator value is exported as a velocity word. The last accepted error sample is exported for downstream health monitoring. One angle count is 360/16384 degrees, about 1.3 arc minutes.

Top module: `atl_tracker`

## Requirements
- R1: While `rst_ni` is low, `angle_o`, `vel_o` and `err_o` are zero. After release with no accepted sample, `angle_o` stays at zero.
- R2: On a clock edge where `err_valid_i` is high, `err_o` takes the value of `err_i`. At all other edges it holds.
- R3: On a clock edge where `err_valid_i` is high, `vel_o` becomes `vel_o + err_i*2^KI_SHIFT`, saturated to ±(2^(INT_W-1)-1). At all other edges it holds.
- R4: Between two consecutive clock edges, `angle_o` changes by 0, +1 or -1 modulo 2^ANG_W.
- R5: A positive command moves the angle up and a negative command moves it down. Counting down from 0 gives 2^ANG_W-1 (16383 by default).
- R6: With the command saturated, the angle steps on at least 99 of any 100 consecutive clocks, and never more than once per clock.
- R7: With the input angle turning at constant speed in either direction, the steady-state difference stays within 6 counts and its mean is within 1 count, so there is no velocity lag.
- R8: In steady tracking, `vel_o` equals the angle rate in counts per clock times 2^(PH_W-1), within 64.
- R9: `err_i` has no effect on any output while `err_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | Marks `err_i` as a fresh sample for one cycle |
| err_i | input | ERR_W | Signed demodulated error sample |
| angle_o | output | ANG_W | Tracked angle, natural binary |
| vel_o | output | INT_W | Signed velocity word (integrator state) |
| err_o | output | ERR_W | Last accepted error sample |

## Verification
The assertions assume only two things about the inputs. First, `err_i` and `err_valid_i` are settled at the rising edge. Second, the command reaching the pulse generator never takes its most negative code; the filter's clamp guarantees this. The bench drives every input on falling edges. In closed loop, it derives each error sample from the sine of the wrapped difference between its own angle and `angle_o`, so samples stay well inside the error range and never use the most negative code. Open-loop saturation runs use ±32767 only.

// File: rtl/atl_pkg.sv
package atl_pkg;
  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction
endpackage

// File: rtl/atl_loop_filter.sv
module atl_loop_filter #(
  parameter int ERR_W      = 16,
  parameter int INT_W      = 24,
  parameter int PH_W       = 16,
  parameter int KI_SHIFT   = 2,
  parameter int KP_SHIFT   = 7,
  parameter int POLE_SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic signed [ERR_W-1:0] err_o,
  output logic signed [INT_W-1:0] vel_o,
  output logic signed [PH_W-1:0]  cmd_o
);
  localparam int MAX_SH = (KP_SHIFT > KI_SHIFT) ? KP_SHIFT : KI_SHIFT;
  localparam int SUM_W  = atl_pkg::max3(INT_W, PH_W, ERR_W + MAX_SH) + 2;
  localparam logic signed [SUM_W-1:0] INT_MAX =
    $signed({{(SUM_W-INT_W+1){1'b0}}, {(INT_W-1){1'b1}}});
  localparam logic signed [SUM_W-1:0] CMD_MAX =
    $signed({{(SUM_W-PH_W+1){1'b0}}, {(PH_W-1){1'b1}}});

  logic signed [ERR_W-1:0] err_q;
  logic signed [INT_W-1:0] integ_q, integ_d;
  logic signed [SUM_W-1:0] in_x, hold_x, integ_x, acc_sum, acc_cl, tgt_sum, tgt_cl;
  logic signed [PH_W-1:0]  tgt;

  always_comb begin
    in_x    = SUM_W'(err_i);
    hold_x  = SUM_W'(err_q);
    integ_x = SUM_W'(integ_q);
    acc_sum = integ_x + (in_x <<< KI_SHIFT);
    if (acc_sum > INT_MAX)       acc_cl = INT_MAX;
    else if (acc_sum < -INT_MAX) acc_cl = -INT_MAX;
    else                         acc_cl = acc_sum;
    integ_d = INT_W'(acc_cl);
    // lead path: proportional term on the held sample
    tgt_sum = integ_x + (hold_x <<< KP_SHIFT);
    if (tgt_sum > CMD_MAX)       tgt_cl = CMD_MAX;
    else if (tgt_sum < -CMD_MAX) tgt_cl = -CMD_MAX;
    else                         tgt_cl = tgt_sum;
    tgt = PH_W'(tgt_cl);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q   <= '0;
      integ_q <= '0;
    end else if (valid_i) begin
      err_q   <= err_i;
      integ_q <= integ_d;
    end
  end

  generate
    if (POLE_SHIFT == 0) begin : g_no_pole
      assign cmd_o = tgt;
    end else begin : g_pole
      logic signed [PH_W-1:0] cmd_q;
      logic signed [PH_W:0]   gap;
      always_comb gap = (PH_W+1)'(tgt) - (PH_W+1)'(cmd_q);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cmd_q <= '0;
        else         cmd_q <= cmd_q + PH_W'(gap >>> POLE_SHIFT);
      end
      assign cmd_o = cmd_q;
    end
  endgenerate

  assign err_o = err_q;
  assign vel_o = integ_q;

  p_err_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(err_q));
  p_integ_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(integ_q));
  p_integ_floor_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    integ_q != $signed({1'b1, {(INT_W-1){1'b0}}}));
endmodule

// File: rtl/atl_nco.sv
module atl_nco #(
  parameter int PH_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic signed [PH_W-1:0] inc_i,
  output logic                   up_o,
  output logic                   dn_o
);
  localparam logic signed [PH_W:0] THR = $signed({2'b01, {(PH_W-1){1'b0}}});

  logic signed [PH_W-1:0] phase_q;
  logic signed [PH_W:0]   sum, nxt;

  always_comb begin
    sum  = (PH_W+1)'(phase_q) + (PH_W+1)'(inc_i);
    up_o = 1'b0;
    dn_o = 1'b0;
    nxt  = sum;
    if (sum >= THR) begin
      up_o = 1'b1;
      nxt  = sum - THR;
    end else if (sum <= -THR) begin
      dn_o = 1'b1;
      nxt  = sum + THR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= PH_W'(nxt);
  end

  p_phase_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q != $signed({1'b1, {(PH_W-1){1'b0}}}));
  p_up_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> (inc_i > 0));
  p_dn_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_o |-> (inc_i < 0));
endmodule

// File: rtl/atl_angle_cnt.sv
module atl_angle_cnt #(
  parameter int ANG_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             up_i,
  input  logic             dn_i,
  output logic [ANG_W-1:0] angle_o
);
  logic [ANG_W-1:0] angle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   angle_q <= '0;
    else if (up_i) angle_q <= angle_q + ANG_W'(1);
    else if (dn_i) angle_q <= angle_q - ANG_W'(1);
  end

  assign angle_o = angle_q;

  p_single_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (ANG_W'(angle_q - $past(angle_q)) inside {'0, ANG_W'(1), '1}));
endmodule

// File: rtl/atl_tracker.sv
module atl_tracker #(
  parameter int ANG_W      = 14,
  parameter int ERR_W      = 16,
  parameter int INT_W      = 24,
  parameter int PH_W       = 16,
  parameter int KI_SHIFT   = 2,
  parameter int KP_SHIFT   = 7,
  parameter int POLE_SHIFT = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_valid_i,
  input  logic signed [ERR_W-1:0] err_i,
  output logic [ANG_W-1:0]        angle_o,
  output logic signed [INT_W-1:0] vel_o,
  output logic signed [ERR_W-1:0] err_o
);
  logic signed [PH_W-1:0] cmd;
  logic                   step_up, step_dn;

  atl_loop_filter #(
    .ERR_W(ERR_W), .INT_W(INT_W), .PH_W(PH_W),
    .KI_SHIFT(KI_SHIFT), .KP_SHIFT(KP_SHIFT), .POLE_SHIFT(POLE_SHIFT)
  ) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(err_valid_i), .err_i(err_i),
    .err_o(err_o), .vel_o(vel_o), .cmd_o(cmd)
  );

  atl_nco #(.PH_W(PH_W)) u_nco (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cmd), .up_o(step_up), .dn_o(step_dn)
  );

  atl_angle_cnt #(.ANG_W(ANG_W)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .up_i(step_up), .dn_i(step_dn), .angle_o(angle_o)
  );
endmodule

// File: tb/atl_tracker_test.sv
`timescale 1ns/1ps
module atl_tracker_test;
  localparam int ANG_W = 14, ERR_W = 16, INT_W = 24, PH_W = 16;
  localparam int KI_SHIFT = 2, KP_SHIFT = 7, POLE_SHIFT = 3;
  localparam longint INT_LIM = (longint'(1) <<< (INT_W-1)) - 1;
  localparam real FULL = 16384.0;

  logic clk = 1'b0, rst_n = 1'b0, vld = 1'b0;
  logic signed [ERR_W-1:0] err = '0;
  logic [ANG_W-1:0] ang;
  logic signed [INT_W-1:0] vel;
  logic signed [ERR_W-1:0] err_q;

  int n_tests = 0, n_fail = 0, last_delta = 0;
  longint exp_vel = 0;
  longint exp_err = 0;

  always #10 clk = ~clk;

  atl_tracker #(.ANG_W(ANG_W), .ERR_W(ERR_W), .INT_W(INT_W), .PH_W(PH_W),
    .KI_SHIFT(KI_SHIFT), .KP_SHIFT(KP_SHIFT), .POLE_SHIFT(POLE_SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(vld), .err_i(err),
    .angle_o(ang), .vel_o(vel), .err_o(err_q));

  function automatic longint sat_int(input longint x);
    if (x > INT_LIM) return INT_LIM;
    if (x < -INT_LIM) return -INT_LIM;
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // one clock: drive after a falling edge, compare at the next one
  task automatic drive(input bit v, input int e);
    logic [ANG_W-1:0] prev, dlt;
    prev = ang;
    vld  = v;
    err  = ERR_W'(e);
    if (v) begin
      exp_vel = sat_int(exp_vel + longint'(e) * (longint'(1) <<< KI_SHIFT));
      exp_err = e;
    end
    @(negedge clk);
    check(longint'(vel) == exp_vel, "R3", "vel_o", longint'(vel), exp_vel);
    check(longint'(err_q) == exp_err, "R2", "err_o", longint'(err_q), exp_err);
    dlt = ang - prev;
    last_delta = (dlt == ANG_W'(1)) ? 1 : (dlt == '1) ? -1 : 0;
    check(dlt == '0 || dlt == ANG_W'(1) || dlt == '1, "R4", "angle delta",
          longint'(dlt), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; err = '0;
    repeat (3) @(negedge clk);
    check(ang == '0, "R1", "angle in reset", longint'(ang), 0);
    check(vel == '0, "R1", "vel in reset", longint'(vel), 0);
    check(err_q == '0, "R1", "err in reset", longint'(err_q), 0);
    rst_n = 1'b1;
    exp_vel = 0;
    exp_err = 0;
  endtask

  function automatic real wrapd(input real d);
    real r;
    r = d;
    while (r >= FULL / 2.0) r -= FULL;
    while (r < -FULL / 2.0) r += FULL;
    return r;
  endfunction

  task automatic track(input real start, input real rate, input int exp_v);
    real th, d, ad, dmax, dsum, x;
    int e, ns;
    do_reset();
    th = start; dmax = 0.0; dsum = 0.0; ns = 0;
    for (int c = 0; c < 30000; c++) begin
      d = wrapd(th - real'(ang));
      x = 8192.0 * $sin(6.283185307179586 * d / FULL);
      e = $rtoi(x + ((x >= 0.0) ? 0.5 : -0.5));
      if (e > 32767) e = 32767;
      if (e < -32767) e = -32767;
      if (c >= 15000) begin
        ad = (d < 0.0) ? -d : d;
        if (ad > dmax) dmax = ad;
        dsum += d;
        ns++;
      end
      drive((c % 16) == 0, e);
      th += rate;
      if (th >= FULL) th -= FULL;
      if (th < 0.0) th += FULL;
    end
    check(dmax <= 6.0, "R7", "peak following error x100", $rtoi(dmax * 100.0), 600);
    x = dsum / real'(ns);
    check(x <= 1.0 && x >= -1.0, "R7", "mean lag x100", $rtoi(x * 100.0), 0);
    check(longint'(vel) <= exp_v + 64 && longint'(vel) >= exp_v - 64, "R8",
          "velocity word", longint'(vel), exp_v);
  endtask

  initial begin
    #(20ns * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int steps, first;
    do_reset();
    // R1, R9: samples without strobe are ignored, angle idles
    for (int i = 0; i < 40; i++) drive(0, 12345 - i * 997);
    check(ang == '0, "R9", "angle idle", longint'(ang), 0);
    check(vel == '0, "R1", "vel idle", longint'(vel), 0);
    // R2, R3: mixed strobed samples
    drive(1, 100); drive(0, -5); drive(0, 777); drive(1, -300);
    for (int i = 0; i < 6; i++) drive(0, 4000 + i);
    check(err_q == -16'sd300, "R2", "held sample", longint'(err_q), -300);
    drive(1, 20); drive(1, -20); drive(1, 0);

    // R3 saturation, R5 positive direction, R6 max rate
    do_reset();
    first = -1;
    for (int i = 0; i < 80; i++) begin
      drive(1, 32767);
      if (first < 0 && ang != '0) first = int'(ang);
    end
    check(longint'(vel) == INT_LIM, "R3", "integrator clamp", longint'(vel), INT_LIM);
    check(first == 1, "R5", "first up step", first, 1);
    repeat (120) drive(0, 0);
    steps = 0;
    for (int i = 0; i < 100; i++) begin
      drive(0, 0);
      if (last_delta == 1) steps++;
    end
    check(steps >= 99, "R6", "up steps per 100", steps, 99);

    // R5 wrap below zero, R6 down rate
    do_reset();
    drive(1, -32767);
    first = -1;
    for (int i = 0; i < 30; i++) begin
      drive(0, 0);
      if (first < 0 && ang != '0) first = int'(ang);
    end
    check(first == 16383, "R5", "wrap below zero", first, 16383);
    repeat (120) drive(0, 0);
    steps = 0;
    for (int i = 0; i < 100; i++) begin
      drive(0, 0);
      if (last_delta == -1) steps++;
    end
    check(steps >= 99, "R6", "down steps per 100", steps, 99);

    // R7, R8: constant speed both ways (1/64 and -1/32 counts per clock)
    track(20.0, 1.0 / 64.0, 512);
    track(16370.0, -1.0 / 32.0, -1024);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule